// File: doc/BRIEF.md
# Three-State Invalidating Snoop Cache Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Each line is either invalid, shared (clean, possibly copied elsewhere) or modified (the only copy, dirty). The processor holds a load or store request until the block signals completion. A hit that needs no bus traffic completes in the cycle it is presented. Anything else raises a bus request and waits for an external grant. Every bus transaction is atomic and finishes within its granted cycle, so the line never passes through an intermediate state.

The other side of the block watches transactions placed on the bus by the other caches. In the same cycle it reports whether it holds a copy and whether that copy is dirty, and a dirty copy drives its data so that memory and the requester are updated together. A snooped exclusive read or upgrade removes the local copy. A snooped plain read to a dirty line drops it to shared.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is invalid: `cpu_done_o` and `bus_req_o` are low, and a snoop to any address reports no copy.
- R2: The line index is the low log2(LINES) address bits and the tag is the remaining bits. A load whose tag matches a shared or modified line asserts `cpu_done_o` in the same cycle with the line data on `cpu_rdata_o`, and raises no bus request.
- R3: Bus commands are encoded 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back. A load miss requests the bus with command 1 at the load address. In the granted cycle it completes, returns `bus_rdata_i`, and fills the line as shared.
- R4: A store whose tag matches no valid line requests command 2. In the granted cycle it completes and leaves the line modified, holding the store data.
- R5: A store to a shared line issues command 3 and uses no bus data. In the granted cycle it completes and leaves the line modified, holding the store data.
- R6: A store to a modified line completes in the same cycle without a bus request and replaces the line data.
- R7: A miss that lands on a modified line with another tag first issues command 4, with the old line's address on `bus_addr_o` and its data on `bus_wdata_o`. The fill transaction follows. A shared victim is replaced without a write-back.
- R8: A snooped read (command 1) to a modified line asserts `snp_dirty_o` and drives the line data on `snp_data_o`. The line becomes shared.
- R9: A snooped read-exclusive (command 2) invalidates a shared or modified copy. A modified copy supplies its data.
- R10: A snooped upgrade (command 3) invalidates a shared copy.
- R11: During any snoop, `snp_shared_o` shows a valid copy with a matching tag, and `snp_dirty_o` shows that this copy is modified; `snp_data_o` is zero otherwise. A snooped write-back (command 4) changes no line.
- R12: In a cycle with `snp_valid_i` high, no processor request completes unless it is granted. While the bus is not granted, `bus_req_o` stays high and `cpu_done_o` stays low.
- R13: The command of a pending request is re-derived every cycle from the current line state. A store waiting on an upgrade whose line a snoop invalidates, or a store hit on a modified line that a snoop demotes, issues the command its line now needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request, held until done |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Word address of the request |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_done_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Load data, valid with done |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant; the transaction takes place in this cycle |
| bus_cmd_o | output | 3 | Command of the requested transaction |
| bus_addr_o | output | ADDR_W | Address of the requested transaction |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Fill data from memory or a peer |
| snp_valid_i | input | 1 | A peer transaction is on the bus |
| snp_cmd_i | input | 3 | Snooped command |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | A valid copy is held |
| snp_dirty_o | output | 1 | The held copy is modified and supplies data |
| snp_data_o | output | DATA_W | Data of a modified copy |

## Verification
A snoop and a pending processor request can fall in the same cycle. This is the collision the bench provokes deliberately. It presents a load hit together with a harmless snoop and expects completion to slip by one cycle. It presents a store hit on a modified line together with a snooped read to that line, expecting a dirty response, no completion, and then an upgrade. It presents a waiting upgrade together with a peer upgrade to the same line, expecting the request to turn into a read-exclusive. A line-state model in the bench predicts every response and command, and a bench memory absorbs write-backs and dirty snoop data.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHD = 2'd1,
    LS_MOD = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_UPG  = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output line_st_e          cpu_st_o,
  output logic [TAG_W-1:0]  cpu_tag_o,
  output logic [DATA_W-1:0] cpu_data_o,
  input  logic [IDX_W-1:0]  snp_idx_i,
  output line_st_e          snp_st_o,
  output logic [TAG_W-1:0]  snp_tag_o,
  output logic [DATA_W-1:0] snp_data_o,
  input  logic              lw_en_i,
  input  line_st_e          lw_st_i,
  input  logic              lw_fill_i,
  input  logic [TAG_W-1:0]  lw_tag_i,
  input  logic [DATA_W-1:0] lw_data_i,
  input  logic              sw_en_i,
  input  line_st_e          sw_st_i
);
  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]   <= LS_INV;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (sw_en_i && snp_idx_i == IDX_W'(g)) begin
        st_q[g] <= sw_st_i;
      end else if (lw_en_i && cpu_idx_i == IDX_W'(g)) begin
        st_q[g] <= lw_st_i;
        if (lw_fill_i) begin
          tag_q[g]  <= lw_tag_i;
          data_q[g] <= lw_data_i;
        end
      end
    end
  end

  assign cpu_st_o   = st_q[cpu_idx_i];
  assign cpu_tag_o  = tag_q[cpu_idx_i];
  assign cpu_data_o = data_q[cpu_idx_i];
  assign snp_st_o   = st_q[snp_idx_i];
  assign snp_tag_o  = tag_q[snp_idx_i];
  assign snp_data_o = data_q[snp_idx_i];

  AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lw_en_i && sw_en_i)); // R12

  AST_LOCAL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_en_i |=> st_q[$past(cpu_idx_i)] == $past(lw_st_i)); // R4
endmodule

// File: rtl/msi_snoop_ctl.sv
module msi_snoop_ctl
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              dirty_o,
  output logic [DATA_W-1:0] data_o,
  output logic              upd_en_o,
  output line_st_e          upd_st_o
);
  logic hit;

  assign hit      = snp_valid_i && (line_st_i != LS_INV) && (line_tag_i == snp_tag_i);
  assign shared_o = hit;
  assign dirty_o  = hit && (line_st_i == LS_MOD);
  assign data_o   = dirty_o ? line_data_i : '0;

  always_comb begin
    upd_en_o = 1'b0;
    upd_st_o = LS_INV;
    if (hit) begin
      unique case (snp_cmd_i)
        3'(BC_RD): begin
          // a peer read demotes a dirty copy
          upd_en_o = (line_st_i == LS_MOD);
          upd_st_o = LS_SHD;
        end
        3'(BC_RDX), 3'(BC_UPG): begin
          upd_en_o = 1'b1;
          upd_st_o = LS_INV;
        end
        default: ;
      endcase
    end
  end

  AST_DIRTY_HAS_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_o |-> shared_o); // R11

  AST_UPG_NEVER_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == 3'(BC_UPG)) |-> !dirty_o); // R10
endmodule

// File: rtl/msi_req_ctl.sv
module msi_req_ctl
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [TAG_W-1:0]  cpu_tag_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              snp_valid_i,
  input  logic              bus_gnt_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_req_o,
  output logic [2:0]        bus_cmd_o,
  output logic [TAG_W-1:0]  bus_tag_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              lw_en_o,
  output line_st_e          lw_st_o,
  output logic              lw_fill_o,
  output logic [TAG_W-1:0]  lw_tag_o,
  output logic [DATA_W-1:0] lw_data_o
);
  logic     tag_hit, fast, evict;
  bus_cmd_e cmd;

  assign tag_hit = (line_st_i != LS_INV) && (line_tag_i == cpu_tag_i);
  assign fast    = tag_hit && (!cpu_we_i || line_st_i == LS_MOD);
  assign evict   = (line_st_i == LS_MOD) && !tag_hit;

  assign bus_tag_o   = evict ? line_tag_i : cpu_tag_i;
  assign bus_wdata_o = evict ? line_data_i : '0;
  assign bus_cmd_o   = 3'(cmd);
  assign lw_tag_o    = cpu_tag_i;

  always_comb begin
    cpu_done_o  = 1'b0;
    cpu_rdata_o = line_data_i;
    bus_req_o   = 1'b0;
    cmd         = BC_NONE;
    lw_en_o     = 1'b0;
    lw_st_o     = LS_INV;
    lw_fill_o   = 1'b0;
    lw_data_o   = cpu_wdata_i;
    if (cpu_req_i) begin
      if (fast) begin
        // snoop owns the line arrays this cycle
        if (!snp_valid_i) begin
          cpu_done_o = 1'b1;
          if (cpu_we_i) begin
            lw_en_o   = 1'b1;
            lw_st_o   = LS_MOD;
            lw_fill_o = 1'b1;
          end
        end
      end else begin
        bus_req_o = 1'b1;
        if (evict)         cmd = BC_WB;
        else if (cpu_we_i) cmd = tag_hit ? BC_UPG : BC_RDX;
        else               cmd = BC_RD;
        if (bus_gnt_i) begin
          lw_en_o = 1'b1;
          unique case (cmd)
            BC_WB: lw_st_o = LS_INV;
            BC_RD: begin
              lw_st_o     = LS_SHD;
              lw_fill_o   = 1'b1;
              lw_data_o   = bus_rdata_i;
              cpu_rdata_o = bus_rdata_i;
              cpu_done_o  = 1'b1;
            end
            default: begin
              lw_st_o    = LS_MOD;
              lw_fill_o  = 1'b1;
              cpu_done_o = 1'b1;
            end
          endcase
        end
      end
    end
  end

  AST_WB_THEN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_req_o && bus_cmd_o == 3'(BC_WB)) |=> (bus_cmd_o != 3'(BC_WB))); // R7

  AST_WB_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == 3'(BC_WB)) |-> !cpu_done_o); // R7
endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_dirty_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag, bus_tag;
  line_st_e          c_st, s_st, lw_st, sw_st;
  logic [TAG_W-1:0]  c_tag, s_tag, lw_tag;
  logic [DATA_W-1:0] c_data, s_data, lw_data;
  logic              lw_en, lw_fill, sw_en;

  assign cpu_idx    = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag    = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx    = snp_addr_i[IDX_W-1:0];
  assign snp_tag    = snp_addr_i[ADDR_W-1:IDX_W];
  assign bus_addr_o = {bus_tag, cpu_idx};

  msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .cpu_idx_i(cpu_idx), .cpu_st_o(c_st), .cpu_tag_o(c_tag), .cpu_data_o(c_data),
    .snp_idx_i(snp_idx), .snp_st_o(s_st), .snp_tag_o(s_tag), .snp_data_o(s_data),
    .lw_en_i(lw_en), .lw_st_i(lw_st), .lw_fill_i(lw_fill), .lw_tag_i(lw_tag),
    .lw_data_i(lw_data), .sw_en_i(sw_en), .sw_st_i(sw_st)
  );

  msi_snoop_ctl #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_cmd_i, .snp_tag_i(snp_tag),
    .line_st_i(s_st), .line_tag_i(s_tag), .line_data_i(s_data),
    .shared_o(snp_shared_o), .dirty_o(snp_dirty_o), .data_o(snp_data_o),
    .upd_en_o(sw_en), .upd_st_o(sw_st)
  );

  msi_req_ctl #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_req (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_tag_i(cpu_tag), .cpu_wdata_i,
    .cpu_done_o, .cpu_rdata_o,
    .snp_valid_i, .bus_gnt_i, .bus_rdata_i,
    .bus_req_o, .bus_cmd_o, .bus_tag_o(bus_tag), .bus_wdata_o,
    .line_st_i(c_st), .line_tag_i(c_tag), .line_data_i(c_data),
    .lw_en_o(lw_en), .lw_st_o(lw_st), .lw_fill_o(lw_fill),
    .lw_tag_o(lw_tag), .lw_data_o(lw_data)
  );

  AST_SNOOP_HOLDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && !bus_gnt_i) |-> !cpu_done_o); // R12

  AST_GRANT_FILL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_req_o && bus_cmd_o != 3'(BC_WB)) |-> cpu_done_o); // R3
endmodule

// File: tb/tb_msi_snoop_cache.sv
`timescale 1ns/1ps
module tb_msi_snoop_cache;
  import msi_pkg::*;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int LINES  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, snp_valid = 0;
  logic [ADDR_W-1:0] cpu_addr = '0, snp_addr = '0, bus_addr;
  logic [DATA_W-1:0] cpu_wdata = '0, rdata, bus_wdata, bus_rdata, snp_data;
  logic [2:0] snp_cmd = '0, bus_cmd;
  logic done, bus_req, snp_shared, snp_dirty;

  logic [DATA_W-1:0] mem [256];
  int               m_st  [LINES];
  logic [5:0]       m_tag [LINES];
  logic [DATA_W-1:0] m_dat [LINES];
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;
  assign bus_rdata = mem[bus_addr];

  msi_snoop_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(done), .cpu_rdata_o(rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_dirty_o(snp_dirty), .snp_data_o(snp_data)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic grant_step(input logic [2:0] cmd, input logic [7:0] a, input int wn, input string rq);
    for (int w = 0; w < wn; w++) begin
      chk("R12", "req while waiting", 32'(bus_req), 1);
      chk("R12", "done while waiting", 32'(done), 0);
      chk(rq, "cmd while waiting", 32'(bus_cmd), 32'(cmd));
      @(negedge clk); #1;
    end
    bus_gnt = 1'b1; #1;
    chk(rq, "req", 32'(bus_req), 1);
    chk(rq, "cmd", 32'(bus_cmd), 32'(cmd));
    chk(rq, "addr", 32'(bus_addr), 32'(a));
  endtask

  task automatic access(input bit we, input logic [7:0] a, input logic [31:0] wd, input int wn);
    int ix;
    logic [5:0] tg;
    logic [7:0] va;
    logic [2:0] cmd;
    string rq;
    bit hit;
    ix  = int'(a[1:0]);
    tg  = a[7:2];
    hit = (m_st[ix] != 0) && (m_tag[ix] == tg);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; bus_gnt = 1'b0; #1;
    if (hit && (!we || m_st[ix] == 2)) begin
      rq = we ? "R6" : "R2";
      chk(rq, "fast done", 32'(done), 1);
      chk(rq, "no bus req", 32'(bus_req), 0);
      if (!we) chk(rq, "rdata", rdata, m_dat[ix]);
      else begin m_dat[ix] = wd; m_st[ix] = 2; end
      @(posedge clk);
    end else begin
      if (m_st[ix] == 2 && !hit) begin
        va = {m_tag[ix], 2'(ix)};
        grant_step(3'(BC_WB), va, wn, "R7");
        chk("R7", "wb data", bus_wdata, m_dat[ix]);
        chk("R7", "no done on wb", 32'(done), 0);
        @(posedge clk);
        mem[va] = m_dat[ix];
        m_st[ix] = 0;
        @(negedge clk); bus_gnt = 1'b0; #1;
      end
      // a shared victim (R7) needs no write-back: the model goes straight to the fill
      if (!we)     begin cmd = 3'(BC_RD);  rq = "R3"; end
      else if (hit) begin cmd = 3'(BC_UPG); rq = "R5"; end
      else         begin cmd = 3'(BC_RDX); rq = "R4"; end
      grant_step(cmd, a, wn, rq);
      chk(rq, "done on grant", 32'(done), 1);
      if (!we) begin
        chk(rq, "fill rdata", rdata, mem[a]);
        m_dat[ix] = mem[a]; m_st[ix] = 1;
      end else begin
        m_dat[ix] = wd; m_st[ix] = 2;
      end
      m_tag[ix] = tg;
      @(posedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b0;
  endtask

  task automatic snoop(input logic [2:0] cmd, input logic [7:0] a, input string rq);
    int ix;
    bit hit, dirty;
    ix = int'(a[1:0]);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a; #1;
    hit   = (m_st[ix] != 0) && (m_tag[ix] == a[7:2]);
    dirty = hit && (m_st[ix] == 2);
    chk(rq, "snp shared", 32'(snp_shared), 32'(hit));
    chk(rq, "snp dirty", 32'(snp_dirty), 32'(dirty));
    chk(rq, "snp data", snp_data, dirty ? m_dat[ix] : 32'h0);
    @(posedge clk);
    if (hit) begin
      if (cmd == 3'(BC_RD) && dirty) begin mem[a] = m_dat[ix]; m_st[ix] = 1; end
      else if (cmd == 3'(BC_RDX)) begin if (dirty) mem[a] = m_dat[ix]; m_st[ix] = 0; end
      else if (cmd == 3'(BC_UPG)) m_st[ix] = 0;
    end
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h0101_0101) ^ 32'h5a00_00c3;
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    #12;
    chk("R1", "done in reset", 32'(done), 0);
    chk("R1", "bus req in reset", 32'(bus_req), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < LINES; i++) snoop(3'(BC_WB), 8'(i), "R1");

    // sweep every line across three tags and several grant delays
    for (int i = 0; i < LINES; i++) begin
      for (int t = 0; t < 3; t++) begin
        logic [7:0] a;
        logic [31:0] wd;
        int wn;
        a  = 8'(t * 16 + i);
        wd = {a, 8'h5c, 8'(t), 8'(i)};
        wn = (i + t) % 3;
        access(1'b0, a, '0, wn);
        access(1'b0, a, '0, 0);
        access(1'b1, a, wd, wn);
        access(1'b1, a, wd ^ 32'h00ff_00ff, 0);
        access(1'b0, a, '0, 0);
        snoop(3'(BC_WB), a, "R11");
        snoop(3'(BC_RD), a, "R8");
        snoop(3'(BC_WB), a, "R8");
        access(1'b0, a, '0, 0);
        snoop(3'(BC_RDX), a, "R9");
        snoop(3'(BC_WB), a, "R9");
        access(1'b1, a, ~wd, wn);
        if (t == 2) begin
          snoop(3'(BC_RDX), a, "R9");
          snoop(3'(BC_WB), a, "R9");
        end
      end
    end

    // peer upgrades against shared lines, then clean-victim replacement (R7)
    for (int i = 0; i < LINES; i++) begin
      access(1'b0, 8'(i), '0, 1);
      snoop(3'(BC_UPG), 8'(i), "R10");
      snoop(3'(BC_WB), 8'(i), "R10");
      access(1'b0, 8'(i + 64), '0, 0);
      access(1'b0, 8'(i + 128), '0, 1);
      snoop(3'(BC_WB), 8'(i + 64), "R7");
    end

    // load hit collides with a snoop: completion slips one cycle
    access(1'b0, 8'h13, '0, 0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h13;
    snp_valid = 1'b1; snp_cmd = 3'(BC_WB); snp_addr = 8'h00; #1;
    chk("R12", "hit held by snoop", 32'(done), 0);
    chk("R12", "no bus req on held hit", 32'(bus_req), 0);
    @(negedge clk); snp_valid = 1'b0; #1;
    chk("R12", "hit after snoop", 32'(done), 1);
    chk("R12", "rdata after snoop", rdata, m_dat[3]);
    @(negedge clk); cpu_req = 1'b0;

    // store hit on a modified line collides with a peer read of that line
    access(1'b0, 8'h05, '0, 0);
    access(1'b1, 8'h05, 32'hd1d1_0005, 0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h05; cpu_wdata = 32'hd2d2_0005;
    snp_valid = 1'b1; snp_cmd = 3'(BC_RD); snp_addr = 8'h05; #1;
    chk("R12", "store held by snoop", 32'(done), 0);
    chk("R8", "dirty on collision", 32'(snp_dirty), 1);
    chk("R8", "data on collision", snp_data, 32'hd1d1_0005);
    @(posedge clk);
    mem[8'h05] = 32'hd1d1_0005; m_st[1] = 1;
    @(negedge clk); snp_valid = 1'b0; #1;
    chk("R13", "demoted store asks upgrade", 32'(bus_cmd), 32'(BC_UPG));
    chk("R13", "demoted store requests", 32'(bus_req), 1);
    bus_gnt = 1'b1; #1;
    chk("R13", "upgrade done", 32'(done), 1);
    @(posedge clk);
    m_st[1] = 2; m_dat[1] = 32'hd2d2_0005;
    @(negedge clk); cpu_req = 1'b0; bus_gnt = 1'b0;
    snoop(3'(BC_WB), 8'h05, "R13");

    // pending upgrade loses its shared copy to a peer upgrade
    access(1'b0, 8'h26, '0, 0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h26; cpu_wdata = 32'hd3d3_0026; #1;
    chk("R5", "upgrade pending", 32'(bus_cmd), 32'(BC_UPG));
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 3'(BC_UPG); snp_addr = 8'h26; #1;
    chk("R12", "no done while peer upgrades", 32'(done), 0);
    chk("R10", "copy seen by peer upgrade", 32'(snp_shared), 1);
    @(posedge clk); m_st[2] = 0;
    @(negedge clk); snp_valid = 1'b0; #1;
    chk("R13", "lost upgrade becomes rdx", 32'(bus_cmd), 32'(BC_RDX));
    bus_gnt = 1'b1; #1;
    chk("R13", "rdx done", 32'(done), 1);
    @(posedge clk);
    m_st[2] = 2; m_dat[2] = 32'hd3d3_0026; m_tag[2] = 6'h09;
    @(negedge clk); cpu_req = 1'b0; bus_gnt = 1'b0;
    snoop(3'(BC_WB), 8'h26, "R13");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule